// File: doc/BRIEF.md
# Programmable PRBS and Repetitive Pattern Generator

This block is the transmit-side stimulus source of a bit error rate tester. It emits one serial bit on every enabled clock. In pseudorandom mode the bits come from a Fibonacci linear feedback shift register. Software sets the register length and the feedback tap mask, so any maximal-length sequence up to 2^32-1 bits can be produced. In repetitive mode a software-loaded word of 1 to 32 bits is sent over and over, most significant bit first.

A gapping enable stalls the whole generator. Fractional or per-channel payloads therefore carry the pattern only in their enabled bit slots. Deliberate errors can be injected as a single inverted bit on command, or continuously at one error per 10^n enabled bits for n from 1 to 7. Injection inverts the emitted bit only and never disturbs the pattern state.

Configuration goes through a small write-only register port. Register CTRL (address 0) holds the source select in bit 0 (0 = pseudorandom, 1 = repetitive) and the error rate code in bits 3:1. Register LEN (address 1) holds the length in bits 5:0. Register TAPS (address 2) holds the tap mask, where bit k feeds back stage k. Register WORD (address 3) holds the repeat word. Register CMD (address 4) fires an error when bit 0 is 1. Each write to CTRL, LEN, TAPS or WORD is followed by one reload cycle, in which the pattern restarts and the bit slot is not used.

Top module: `prbs_pattern_gen`

## Requirements
- R1: After reset tx_data is 0, and the block is in pseudorandom mode with length 32, taps 32'h8020_0003, rate code 0 and a zero word. The first enabled bit after reset is the seed bit 1.
- R2: In pseudorandom mode with length L, every enabled bit emits stage L-1 of the state. The state then shifts up by one, and the new stage 0 is the XOR of the state bits selected by both the tap mask and the length mask. Primitive taps give a period of 2^L-1 with 2^(L-1) ones.
- R3: A stored length below 2 acts as 2, and one above 32 acts as 32. On reset and on each reload the state is loaded with all L bits set. A shift that would give an all-zero state loads the all-ones seed instead.
- R4: In repetitive mode with length L (0 acts as 1, above 32 acts as 32), the enabled bits are WORD[L-1], WORD[L-2], ... WORD[0], and the sequence then starts again. A reload restarts it at WORD[L-1].
- R5: While bit_en is 0, tx_data holds its value and the pattern does not advance. The reload cycle after a configuration write also emits nothing.
- R6: Writing CMD with bit 0 set inverts the next enabled bit only, and the sequence after it continues uncorrupted. Writing CMD with bit 0 clear has no effect, and a CMD write causes no reload.
- R7: Rate code n in 1..7 inverts exactly one bit in every 10^n enabled bits: the 10^n-th, 2*10^n-th, ... bit after the reload. Rate code 0 injects nothing.
- R8: Writes to addresses 5 to 7 are ignored. They cause no reload and leave the running pattern undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Gapping enable: 1 = this clock carries a bit |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| tx_data | output | 1 | Registered serial test pattern |

## Verification
A wrong feedback bit or a wrong length mask shows at tx_data within L enabled bits, because every state bit reaches stage L-1 by then. The short sequences are compared over two full periods, and their period and ones count are checked as well. A pointer or gap fault in repetitive mode shows within one word length. A fault in the decade counter shows as a misplaced or missing inverted bit at the 10^n-th enabled bit of all-zero traffic. Inject-path faults are caught by comparing the bits that follow a single error with the uncorrupted pattern model.

// File: rtl/pg_pkg.sv
`timescale 1ns/1ps
package pg_pkg;

   typedef enum logic [2:0] {
      REG_CTRL = 3'd0,
      REG_LEN  = 3'd1,
      REG_TAPS = 3'd2,
      REG_WORD = 3'd3,
      REG_CMD  = 3'd4
   } reg_addr_e;

   typedef enum logic {
      SRC_PRBS   = 1'b0,
      SRC_REPEAT = 1'b1
   } src_mode_e;

   // integer power of ten, used for the decade error limits
   function automatic int unsigned pow10(input int n);
      int unsigned v;
      v = 1;
      for (int i = 0; i < n; i++) v = v * 10;
      return v;
   endfunction

endpackage

// File: rtl/pg_lfsr_core.sv
`timescale 1ns/1ps
module pg_lfsr_core #(
   parameter int W  = 32,
   parameter int LW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          adv,
   input  logic [LW-1:0] len,
   input  logic [W-1:0]  taps,
   output logic          bit_o
);

   logic [W-1:0] state_q;
   logic [W-1:0] len_mask;
   logic [W-1:0] top_sel;
   logic [W-1:0] shifted;
   logic [W-1:0] next_state;
   logic         fb;

   // one mask bit per stage that lies inside the programmed length
   genvar gi;
   generate
      for (gi = 0; gi < W; gi++) begin : g_len_mask
         assign len_mask[gi] = (len > LW'(gi));
      end
   endgenerate

   assign top_sel    = len_mask ^ (len_mask >> 1);
   assign bit_o      = |(state_q & top_sel);
   assign fb         = ^(state_q & taps & len_mask);
   assign shifted    = {state_q[W-2:0], fb} & len_mask;
   assign next_state = (shifted == '0) ? len_mask : shifted;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    state_q <= '1;
      else if (load) state_q <= len_mask;
      else if (adv)  state_q <= next_state;
   end

   a_r3_state_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      !load |-> ((state_q & len_mask) != '0));

   a_r2_hold_without_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !adv) |=> $stable(state_q));

endmodule

// File: rtl/pg_repeat_core.sv
`timescale 1ns/1ps
module pg_repeat_core #(
   parameter int W  = 32,
   parameter int LW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          adv,
   input  logic [LW-1:0] len,
   input  logic [W-1:0]  word,
   output logic          bit_o
);

   logic [LW-1:0] ptr_q;
   logic [W-1:0]  word_sh;

   assign word_sh = word >> ptr_q;
   assign bit_o   = word_sh[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ptr_q <= LW'(W - 1);
      else if (load)   ptr_q <= len - LW'(1);
      else if (adv)    ptr_q <= (ptr_q == '0) ? (len - LW'(1)) : (ptr_q - LW'(1));
   end

   a_r4_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      !load |-> (ptr_q < len));

endmodule

// File: rtl/pg_err_inject.sv
`timescale 1ns/1ps
module pg_err_inject #(
   parameter int STEPS = 7,
   parameter int RW    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          adv,
   input  logic [RW-1:0] rate,
   input  logic          single_set,
   output logic          flip
);
   import pg_pkg::*;

   localparam int unsigned MAXLIM = pow10(STEPS);
   localparam int          CW     = (MAXLIM > 1) ? $clog2(MAXLIM) : 1;
   localparam int          NTAB   = 1 << RW;

   logic          pending_q;
   logic          rate_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pending_q <= 1'b0;
      else if (single_set) pending_q <= 1'b1;
      else if (adv)        pending_q <= 1'b0;
   end

   generate
      if (STEPS > 0) begin : g_rate
         logic [CW-1:0] lim_tab [NTAB];
         logic [CW-1:0] limit;
         logic [CW-1:0] cnt_q;
         logic          rate_on;

         for (genvar k = 0; k < NTAB; k++) begin : g_tab
            assign lim_tab[k] = (k >= 1 && k <= STEPS) ? CW'(pow10(k)) : CW'(1);
         end

         assign rate_on  = (rate != '0) && (int'(rate) <= STEPS);
         assign limit    = lim_tab[rate];
         assign rate_hit = adv && rate_on && (cnt_q == limit - CW'(1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                cnt_q <= '0;
            else if (clear)            cnt_q <= '0;
            else if (rate_hit)         cnt_q <= '0;
            else if (adv && rate_on)   cnt_q <= cnt_q + CW'(1);
         end

         a_r7_cnt_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
            (rate_on && !clear) |-> (cnt_q < limit));
      end else begin : g_no_rate
         assign rate_hit = 1'b0;
      end
   endgenerate

   assign flip = adv && (pending_q || rate_hit);

   a_r6_flip_needs_slot: assert property (@(posedge clk) disable iff (!rst_n)
      flip |-> adv);

   a_r6_single_consumed: assert property (@(posedge clk) disable iff (!rst_n)
      (pending_q && adv && !single_set) |=> !pending_q);

endmodule

// File: rtl/prbs_pattern_gen.sv
`timescale 1ns/1ps
module prbs_pattern_gen #(
   parameter int           W          = 32,
   parameter int           RATE_STEPS = 7,
   parameter bit           HAS_REPEAT = 1'b1,
   parameter logic [W-1:0] RESET_TAPS = W'(32'h8020_0003)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bit_en,
   input  logic        cfg_we,
   input  logic [2:0]  cfg_addr,
   input  logic [31:0] cfg_wdata,
   output logic        tx_data
);
   import pg_pkg::*;

   localparam int LW = $clog2(W + 1);
   localparam int RW = 3;

   generate
      if (W < 2 || W > 32) begin : g_bad_width
         $error("prbs_pattern_gen: W must lie in 2..32");
      end
      if (RATE_STEPS < 0 || RATE_STEPS > 7) begin : g_bad_steps
         $error("prbs_pattern_gen: RATE_STEPS must lie in 0..7");
      end
   endgenerate

   src_mode_e     mode_q;
   logic [RW-1:0] rate_q;
   logic [5:0]    len_raw_q;
   logic [W-1:0]  taps_q;
   logic [W-1:0]  word_q;
   logic          reload_q;

   logic [LW-1:0] prbs_len;
   logic [LW-1:0] rep_len;
   logic          emit;
   logic          single_set;
   logic          prbs_bit;
   logic          rep_bit;
   logic          flip;
   logic          sel_bit;

   // configuration registers; every pattern-shaping write schedules a reload
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= SRC_PRBS;
         rate_q    <= '0;
         len_raw_q <= 6'(W);
         taps_q    <= RESET_TAPS;
         word_q    <= '0;
         reload_q  <= 1'b0;
      end else begin
         reload_q <= 1'b0;
         if (cfg_we) begin
            case (cfg_addr)
               REG_CTRL: begin
                  mode_q   <= src_mode_e'(cfg_wdata[0]);
                  rate_q   <= cfg_wdata[3:1];
                  reload_q <= 1'b1;
               end
               REG_LEN: begin
                  len_raw_q <= cfg_wdata[5:0];
                  reload_q  <= 1'b1;
               end
               REG_TAPS: begin
                  taps_q   <= cfg_wdata[W-1:0];
                  reload_q <= 1'b1;
               end
               REG_WORD: begin
                  word_q   <= cfg_wdata[W-1:0];
                  reload_q <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   // length clamping for the two sources
   always_comb begin
      if (len_raw_q < 6'd2)        prbs_len = LW'(2);
      else if (len_raw_q > 6'(W))  prbs_len = LW'(W);
      else                         prbs_len = LW'(len_raw_q);

      if (len_raw_q < 6'd1)        rep_len = LW'(1);
      else if (len_raw_q > 6'(W))  rep_len = LW'(W);
      else                         rep_len = LW'(len_raw_q);
   end

   assign emit       = bit_en && !reload_q;
   assign single_set = cfg_we && (cfg_addr == REG_CMD) && cfg_wdata[0];

   pg_lfsr_core #(.W(W), .LW(LW)) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (reload_q),
      .adv   (emit && (mode_q == SRC_PRBS)),
      .len   (prbs_len),
      .taps  (taps_q),
      .bit_o (prbs_bit)
   );

   generate
      if (HAS_REPEAT) begin : g_repeat
         pg_repeat_core #(.W(W), .LW(LW)) u_repeat (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (reload_q),
            .adv   (emit && (mode_q == SRC_REPEAT)),
            .len   (rep_len),
            .word  (word_q),
            .bit_o (rep_bit)
         );
      end else begin : g_no_repeat
         assign rep_bit = 1'b0;
      end
   endgenerate

   pg_err_inject #(.STEPS(RATE_STEPS), .RW(RW)) u_inject (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (reload_q),
      .adv        (emit),
      .rate       (rate_q),
      .single_set (single_set),
      .flip       (flip)
   );

   assign sel_bit = (mode_q == SRC_REPEAT) ? rep_bit : prbs_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    tx_data <= 1'b0;
      else if (emit) tx_data <= sel_bit ^ flip;
   end

   a_r5_hold_when_gapped: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(tx_data));

   a_r5_hold_on_reload: assert property (@(posedge clk) disable iff (!rst_n)
      reload_q |=> $stable(tx_data));

   a_r8_spare_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr > 3'd4) |=> !reload_q);

endmodule

// File: tb/prbs_pattern_gen_tb.sv
`timescale 1ns/1ps
module prbs_pattern_gen_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bit_en;
   logic        cfg_we;
   logic [2:0]  cfg_addr;
   logic [31:0] cfg_wdata;
   logic        tx_data;

   int n_chk  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   prbs_pattern_gen u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_en    (bit_en),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .tx_data   (tx_data)
   );

   // reference model state, built from the requirement text
   logic [31:0] ms, mmask, mtaps;
   int          mlen;
   bit          bq [0:4095];

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic m_load(input int len, input logic [31:0] taps);
      mlen  = len;
      mmask = (len >= 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 32'd1);
      ms    = mmask;
      mtaps = taps;
   endtask

   task automatic m_next(output bit b);
      logic [31:0] ns;
      bit fb;
      b  = ms[mlen-1];
      fb = ^(ms & mtaps & mmask);
      ns = ((ms << 1) | {31'd0, fb}) & mmask;
      if (ns == 32'd0) ns = mmask;
      ms = ns;
   endtask

   // called at a negedge, returns at the next negedge
   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; bit_en = 1'b0;
      @(negedge clk);
      cfg_we = 1'b0;
      @(negedge clk);
   endtask

   task automatic step(input bit en, output bit b);
      bit_en = en;
      @(posedge clk);
      #1 b = tx_data;
      @(negedge clk);
      bit_en = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int          plen [7];
      logic [31:0] ptap [7];
      bit b, e;
      int bad, ones;

      plen = '{6, 9, 11, 15, 20, 23, 32};
      ptap = '{32'h30, 32'h110, 32'h500, 32'h6000, 32'h80004, 32'h420000, 32'h80200003};

      rst_n = 1'b0; bit_en = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check(tx_data == 1'b0, "R1", "reset output", tx_data, 0);

      // R1 defaults: 32-stage sequence from the all-ones seed
      m_load(32, 32'h8020_0003);
      bad = 0;
      for (int i = 0; i < 64; i++) begin
         step(1'b1, b); m_next(e);
         if (i == 0) check(b == 1'b1, "R1", "first bit after reset", b, 1);
         if (b != e) bad++;
      end
      check(bad == 0, "R1", "default sequence mismatches", bad, 0);

      // R2 sweep of the standard polynomials
      for (int p = 0; p < 7; p++) begin
         int per, nb;
         wr(3'd1, plen[p]);
         wr(3'd2, ptap[p]);
         m_load(plen[p], ptap[p]);
         per = (plen[p] <= 11) ? ((1 << plen[p]) - 1) : 0;
         nb  = (per > 0) ? 2 * per : 300;
         bad = 0;
         for (int i = 0; i < nb; i++) begin
            step(1'b1, b); m_next(e);
            bq[i] = b;
            if (b != e) bad++;
         end
         check(bad == 0, "R2", $sformatf("len %0d model mismatches", plen[p]), bad, 0);
         if (per > 0) begin
            int rep_bad;
            rep_bad = 0; ones = 0;
            for (int i = 0; i < per; i++) begin
               if (bq[i] != bq[i+per]) rep_bad++;
               if (bq[i]) ones++;
            end
            check(rep_bad == 0, "R2", $sformatf("len %0d period", plen[p]), rep_bad, 0);
            check(ones == (1 << (plen[p] - 1)), "R2", $sformatf("len %0d ones", plen[p]),
                  ones, 1 << (plen[p] - 1));
         end
      end

      // R3 lock-up recovery: no taps, length 4
      wr(3'd1, 32'd4);
      wr(3'd2, 32'd0);
      bad = 0;
      for (int i = 0; i < 20; i++) begin
         step(1'b1, b);
         if (b != 1'b1) bad++;
      end
      check(bad == 0, "R3", "zero-tap output not all ones", bad, 0);

      // R3 clamp low: length 0 acts as 2, taps x^2+x+1 give 110 repeating
      wr(3'd1, 32'd0);
      wr(3'd2, 32'd3);
      bad = 0;
      for (int i = 0; i < 9; i++) begin
         step(1'b1, b);
         e = (i % 3 != 2);
         if (b != e) bad++;
      end
      check(bad == 0, "R3", "length 0 clamp", bad, 0);

      // R3 clamp high: length 40 acts as 32
      wr(3'd1, 32'd40);
      wr(3'd2, 32'h8020_0003);
      m_load(32, 32'h8020_0003);
      bad = 0;
      for (int i = 0; i < 80; i++) begin
         step(1'b1, b); m_next(e);
         if (b != e) bad++;
      end
      check(bad == 0, "R3", "length 40 clamp", bad, 0);

      // R4 repetitive mode over several lengths
      wr(3'd0, 32'd1);
      wr(3'd3, 32'hC3A5_0F69);
      foreach (plen[q]) begin end
      for (int k = 0; k < 9; k++) begin
         int lraw, leff;
         int lens [9];
         lens = '{0, 1, 2, 3, 5, 8, 17, 32, 63};
         lraw = lens[k];
         leff = (lraw < 1) ? 1 : ((lraw > 32) ? 32 : lraw);
         wr(3'd1, lraw);
         bad = 0;
         for (int i = 0; i < 3 * leff + 2; i++) begin
            logic [31:0] w;
            w = 32'hC3A5_0F69;
            step(1'b1, b);
            e = w[leff - 1 - (i % leff)];
            if (b != e) bad++;
         end
         check(bad == 0, "R4", $sformatf("repeat length %0d", lraw), bad, 0);
      end

      // R5 gapped slots in pseudorandom mode
      wr(3'd0, 32'd0);
      wr(3'd1, 32'd9);
      wr(3'd2, 32'h110);
      m_load(9, 32'h110);
      begin
         bit last;
         int hold_bad;
         bad = 0; hold_bad = 0; last = tx_data;
         for (int i = 0; i < 1500; i++) begin
            bit en;
            en = ($urandom % 3) != 0;
            step(en, b);
            if (en) begin
               m_next(e);
               if (b != e) bad++;
            end else if (b != last) hold_bad++;
            last = b;
         end
         check(bad == 0, "R5", "gapped sequence mismatches", bad, 0);
         check(hold_bad == 0, "R5", "output moved in gap", hold_bad, 0);
      end

      // R6 single error: inverts one bit, pattern continues
      bad = 0;
      for (int i = 0; i < 10; i++) begin step(1'b1, b); m_next(e); if (b != e) bad++; end
      wr(3'd4, 32'd1);
      for (int i = 0; i < 20; i++) begin
         step(1'b1, b); m_next(e);
         if (b != (e ^ (i == 0))) bad++;
      end
      check(bad == 0, "R6", "single inject on running sequence", bad, 0);
      wr(3'd4, 32'd0);
      bad = 0;
      for (int i = 0; i < 10; i++) begin step(1'b1, b); m_next(e); if (b != e) bad++; end
      check(bad == 0, "R6", "CMD with bit 0 clear", bad, 0);
      wr(3'd4, 32'd1);
      begin
         bit last;
         int hb;
         hb = 0; last = tx_data;
         for (int i = 0; i < 3; i++) begin step(1'b0, b); if (b != last) hb++; end
         check(hb == 0, "R6", "pending error waits for slot", hb, 0);
      end
      step(1'b1, b); m_next(e);
      check(b == !e, "R6", "pending error lands in next slot", b, !e);

      // R8 spare addresses change nothing
      wr(3'd5, 32'hFFFF_FFFF);
      wr(3'd6, 32'h0000_0001);
      wr(3'd7, 32'h1234_5678);
      bad = 0;
      for (int i = 0; i < 40; i++) begin step(1'b1, b); m_next(e); if (b != e) bad++; end
      check(bad == 0, "R8", "spare writes disturbed pattern", bad, 0);

      // R7 decade error rates on all-zero traffic
      wr(3'd0, 32'd1);
      wr(3'd3, 32'd0);
      wr(3'd1, 32'd8);
      for (int code = 0; code < 4; code++) begin
         int lim, nb, exp_ones, pos_bad;
         lim = 1;
         for (int j = 0; j < code; j++) lim = lim * 10;
         nb = (code == 3) ? 2000 : 1000;
         wr(3'd0, (code << 1) | 1);
         ones = 0; pos_bad = 0;
         for (int i = 0; i < nb; i++) begin
            step(1'b1, b);
            e = (code != 0) && (((i + 1) % lim) == 0);
            if (b) ones++;
            if (b != e) pos_bad++;
         end
         exp_ones = (code == 0) ? 0 : nb / lim;
         check(ones == exp_ones, "R7", $sformatf("rate code %0d error count", code), ones, exp_ones);
         check(pos_bad == 0, "R7", $sformatf("rate code %0d error placement", code), pos_bad, 0);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule